// File: doc/BRIEF.md
# Sector Write-Protection Arbiter

This block rules on every request that could alter the contents of a serial flash array. For each one it answers allow or deny. It covers programming, the two erase sizes, whole-array erase, and writes to its own protection registers. Two schemes feed the answer, and they work independently. The first is a bank of volatile per-sector locks. The second is a contiguous protected range, anchored at the top or the bottom of the array, taken from a small status field. A write-protect pin can freeze that status field.

The array is split into 64-Kbyte sectors, and the sector number is the upper field of the request address. One request is accepted per cycle while `req_valid` is high. The verdict appears one clock later together with a completion pulse. The surrounding controller uses that pulse to drop its write-enable latch, whether the verdict was allow or deny. Lock-register writes and status writes update the state held here when they are allowed. A query port reads back the lock pair of any sector, and the status field is always visible on output ports.

Top module: `secprot_arbiter`

## Requirements
- R1: A synchronous reset, which stands for power-up, clears every sector's write-lock and lock-down bits, the 3-bit range code, the top/bottom select and the status freeze bit. It also holds `rsp_done` and `rsp_allow` low.
- R2: A program (`req_kind` 0), subsector erase (1) or sector erase (2) is denied when the write-lock bit of sector `req_addr[22:16]` is 1.
- R3: For a range code n from 1 to 7 the protected region holds 2^n sectors. With the top/bottom select at 0 the region is the highest-numbered sectors; with it at 1 the region starts at sector 0. Code 0 protects no sector. A program or erase aimed at a sector in the region is denied, and one aimed at a sector outside the region and not write-locked is allowed.
- R4: A lock write (`req_kind` 4) loads `req_data[0]` into the target sector's write-lock bit and `req_data[1]` into its lock-down bit. It is denied, and the pair is left unchanged, when that sector's lock-down bit is already 1. Only reset clears a set lock-down bit.
- R5: A whole-array erase (`req_kind` 3) is allowed only when the range code is 0 and no sector's write-lock bit is set.
- R6: A status write (`req_kind` 5) loads `req_data[2:0]` as the range code, `req_data[3]` as the top/bottom select and `req_data[4]` as the freeze bit. It is denied with no change when the freeze bit is 1 and `wp_n` is 0. With the freeze bit at 0 the level of `wp_n` has no effect.
- R7: Every accepted request produces `rsp_done` high for exactly the next cycle, with `rsp_allow` giving the verdict in that same cycle. Both are low in a cycle that follows no request. A denied request changes no state.
- R8: Lock writes are not blocked by the range code, and status writes are not blocked by sector locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | 0 program, 1 subsector erase, 2 sector erase, 3 whole erase, 4 lock write, 5 status write |
| req_addr | input | 23 | Target byte address; bits [22:16] select the sector |
| req_data | input | 8 | Payload for lock and status writes |
| wp_n | input | 1 | Write-protect pin, active low |
| qry_sect | input | 7 | Sector whose lock pair is read back |
| rsp_done | output | 1 | Completion pulse (clears the write-enable latch) |
| rsp_allow | output | 1 | Verdict: 1 allow, 0 deny |
| qry_lock | output | 2 | {lock-down, write-lock} of `qry_sect` |
| stat_bp | output | 3 | Range code |
| stat_tb | output | 1 | Top/bottom select |
| stat_srwd | output | 1 | Status freeze bit |

## Verification
Several properties are checked on every cycle. A locked-down sector keeps its lock pair. A frozen status field under a low pin does not move. A write-locked or in-range target never yields an allow. A whole erase with a nonzero code or any lock set is refused. The done pulse follows each request and only a request. The exact shape of the protected range for every code and both anchors is shown only by the bench's sweep over all sectors, and so is the equal treatment of program and the two erase kinds. Two more behaviours also depend on ordered scenarios: release of lock-down by reset, and the independence of lock writes from the range code.

// File: rtl/secprot_pkg.sv
package secprot_pkg;

    typedef enum logic [2:0] {
        OP_PROGRAM    = 3'd0,
        OP_SUB_ERASE  = 3'd1,
        OP_SEC_ERASE  = 3'd2,
        OP_BULK_ERASE = 3'd3,
        OP_LOCK_WR    = 3'd4,
        OP_STAT_WR    = 3'd5
    } op_t;

    typedef struct packed {
        logic lock_down;
        logic write_lock;
    } lock_t;

    typedef struct packed {
        logic       srwd;
        logic       tb;
        logic [2:0] bp;
    } stat_t;

    function automatic logic is_array_op(input op_t op);
        return (op == OP_PROGRAM) || (op == OP_SUB_ERASE) || (op == OP_SEC_ERASE);
    endfunction

    // Protected-range membership: code n > 0 covers 2^n sectors (clipped
    // to the array), at the high end when tb = 0, at the low end when tb = 1.
    function automatic logic in_bp_range(input int sect, input int nsect,
                                         input logic [2:0] bp, input logic tb);
        int span;
        if (bp == 3'd0) return 1'b0;
        span = 1 << bp;
        if (span > nsect) span = nsect;
        if (tb) return sect < span;
        return sect >= (nsect - span);
    endfunction

endpackage

// File: rtl/secprot_lock_bank.sv
module secprot_lock_bank
    import secprot_pkg::*;
#(
    parameter int SECT_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SECT_W-1:0] wr_sect,
    input  lock_t             wr_val,
    input  logic [SECT_W-1:0] rd_a_sect,
    output lock_t             rd_a,
    input  logic [SECT_W-1:0] rd_b_sect,
    output lock_t             rd_b,
    output logic              any_wl
);
    localparam int NUM_SECT = 1 << SECT_W;

    lock_t [NUM_SECT-1:0] locks;
    logic  [NUM_SECT-1:0] wl_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            locks <= '0;
        end else if (wr_en) begin
            locks[wr_sect] <= wr_val;
        end
    end

    for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
        assign wl_vec[g] = locks[g].write_lock;

        // R4
        lockdown_hold_chk: assert property (@(posedge clk) disable iff (rst)
            locks[g].lock_down |=> (locks[g] == $past(locks[g])));
    end

    assign any_wl = |wl_vec;
    assign rd_a   = locks[rd_a_sect];
    assign rd_b   = locks[rd_b_sect];

endmodule

// File: rtl/secprot_status_reg.sv
module secprot_status_reg
    import secprot_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wp_n,
    input  logic  wr_en,
    input  stat_t wr_val,
    output stat_t stat,
    output logic  frozen
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else if (wr_en) begin
            stat <= wr_val;
        end
    end

    assign frozen = stat.srwd && !wp_n;

    // R6
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stat.srwd && !wp_n) |=> (stat == $past(stat)));

endmodule

// File: rtl/secprot_range_decode.sv
module secprot_range_decode
    import secprot_pkg::*;
#(
    parameter int SECT_W = 7
) (
    input  logic [SECT_W-1:0] sect,
    input  stat_t             stat,
    output logic              hit
);
    localparam int NUM_SECT = 1 << SECT_W;

    assign hit = in_bp_range(int'(sect), NUM_SECT, stat.bp, stat.tb);

endmodule

// File: rtl/secprot_arbiter.sv
module secprot_arbiter
    import secprot_pkg::*;
#(
    parameter int ADDR_W   = 23,
    parameter int SECT_LSB = 16,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              wp_n,
    input  logic [ADDR_W-SECT_LSB-1:0] qry_sect,
    output logic              rsp_done,
    output logic              rsp_allow,
    output logic [1:0]        qry_lock,
    output logic [2:0]        stat_bp,
    output logic              stat_tb,
    output logic              stat_srwd
);
    localparam int SECT_W = ADDR_W - SECT_LSB;

    op_t               kind;
    logic [SECT_W-1:0] sect;
    logic [SECT_LSB-1:0] addr_unused;
    logic [DATA_W-6:0] data_unused;
    lock_t             tgt_lock;
    lock_t             qry_val;
    lock_t             lock_wr_val;
    stat_t             stat;
    stat_t             stat_wr_val;
    logic              any_wl;
    logic              frozen;
    logic              range_hit;
    logic              allow;
    logic              lock_we;
    logic              stat_we;

    assign kind        = op_t'(req_kind);
    assign sect        = req_addr[ADDR_W-1:SECT_LSB];
    assign addr_unused = req_addr[SECT_LSB-1:0];
    assign data_unused = req_data[DATA_W-1:5];
    assign lock_wr_val = '{lock_down: req_data[1], write_lock: req_data[0]};
    assign stat_wr_val = '{srwd: req_data[4], tb: req_data[3], bp: req_data[2:0]};

    secprot_lock_bank #(.SECT_W(SECT_W)) u_locks (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (lock_we),
        .wr_sect   (sect),
        .wr_val    (lock_wr_val),
        .rd_a_sect (sect),
        .rd_a      (tgt_lock),
        .rd_b_sect (qry_sect),
        .rd_b      (qry_val),
        .any_wl    (any_wl)
    );

    secprot_status_reg u_stat (
        .clk    (clk),
        .rst    (rst),
        .wp_n   (wp_n),
        .wr_en  (stat_we),
        .wr_val (stat_wr_val),
        .stat   (stat),
        .frozen (frozen)
    );

    secprot_range_decode #(.SECT_W(SECT_W)) u_range (
        .sect (sect),
        .stat (stat),
        .hit  (range_hit)
    );

    always_comb begin
        unique case (kind)
            OP_PROGRAM, OP_SUB_ERASE, OP_SEC_ERASE:
                allow = !tgt_lock.write_lock && !range_hit;
            OP_BULK_ERASE: allow = (stat.bp == 3'd0) && !any_wl;
            OP_LOCK_WR:    allow = !tgt_lock.lock_down;
            OP_STAT_WR:    allow = !frozen;
            default:       allow = 1'b0;
        endcase
    end

    assign lock_we = req_valid && (kind == OP_LOCK_WR) && allow;
    assign stat_we = req_valid && (kind == OP_STAT_WR) && allow;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_done  <= 1'b0;
            rsp_allow <= 1'b0;
        end else begin
            rsp_done  <= req_valid;
            rsp_allow <= req_valid && allow;
        end
    end

    assign qry_lock  = qry_val;
    assign stat_bp   = stat.bp;
    assign stat_tb   = stat.tb;
    assign stat_srwd = stat.srwd;

    // R2
    wl_deny_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_array_op(kind) && tgt_lock.write_lock) |=> (rsp_done && !rsp_allow));

    // R3
    range_deny_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_array_op(kind) && range_hit) |=> !rsp_allow);

    // R5
    bulk_deny_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && kind == OP_BULK_ERASE && (stat.bp != 3'd0 || any_wl)) |=> !rsp_allow);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_done);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_done && !rsp_allow));

endmodule

// File: tb/tb_secprot_arbiter.sv
module tb_secprot_arbiter;

    localparam int NS = 128;
    localparam logic [2:0] K_PROG = 3'd0, K_SUB = 3'd1, K_SEC = 3'd2,
                           K_BULK = 3'd3, K_LOCK = 3'd4, K_STAT = 3'd5;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  req_kind;
    logic [22:0] req_addr;
    logic [7:0]  req_data;
    logic        wp_n;
    logic [6:0]  qry_sect;
    logic        rsp_done, rsp_allow, stat_tb, stat_srwd;
    logic [1:0]  qry_lock;
    logic [2:0]  stat_bp;

    int vectors = 0;
    int errors  = 0;

    logic       m_wl [NS];
    logic       m_ld [NS];
    logic [2:0] m_bp;
    logic       m_tb, m_srwd;

    always #10 clk = ~clk;

    secprot_arbiter dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_data(req_data), .wp_n(wp_n), .qry_sect(qry_sect),
        .rsp_done(rsp_done), .rsp_allow(rsp_allow), .qry_lock(qry_lock),
        .stat_bp(stat_bp), .stat_tb(stat_tb), .stat_srwd(stat_srwd)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit prot(input int s);
        int span;
        if (m_bp == 3'd0) return 1'b0;
        span = 1 << m_bp;
        return m_tb ? (s < span) : (s >= NS - span);
    endfunction

    function automatic bit exp_allow(input logic [2:0] k, input int s,
                                     input logic [7:0] d, input logic wp);
        bit any;
        any = 1'b0;
        for (int i = 0; i < NS; i++) if (m_wl[i]) any = 1'b1;
        case (k)
            K_PROG, K_SUB, K_SEC: return !m_wl[s] && !prot(s);
            K_BULK: return (m_bp == 3'd0) && !any;
            K_LOCK: return !m_ld[s];
            K_STAT: return !(m_srwd && !wp);
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin m_wl[i] = 1'b0; m_ld[i] = 1'b0; end
        m_bp = 3'd0; m_tb = 1'b0; m_srwd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // One request; verdict and state sampled at the negedge after the capture edge.
    task automatic do_req(input string req, input logic [2:0] k, input int s,
                          input logic [7:0] d, input logic wp);
        bit e;
        @(negedge clk);
        e = exp_allow(k, s, d, wp);
        req_valid = 1'b1; req_kind = k;
        req_addr  = {7'(s), 16'(s * 37 + 5)};
        req_data  = d; wp_n = wp; qry_sect = 7'(s);
        @(negedge clk);
        req_valid = 1'b0;
        if (e && k == K_LOCK) begin m_wl[s] = d[0]; m_ld[s] = d[1]; end
        if (e && k == K_STAT) begin m_bp = d[2:0]; m_tb = d[3]; m_srwd = d[4]; end
        chk({req, " done (R7)"}, int'(rsp_done), 1);
        chk({req, " allow"}, int'(rsp_allow), int'(e));
        chk({req, " lock pair"}, int'(qry_lock), int'({m_ld[s], m_wl[s]}));
        chk({req, " status"}, int'({stat_srwd, stat_tb, stat_bp}), int'({m_srwd, m_tb, m_bp}));
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_kind = 3'd0; req_addr = '0;
        req_data = '0; wp_n = 1'b1; qry_sect = '0;
        do_reset();

        // R1 reset state
        @(negedge clk);
        chk("R1 done", int'(rsp_done), 0);
        chk("R1 allow", int'(rsp_allow), 0);
        chk("R1 status", int'({stat_srwd, stat_tb, stat_bp}), 0);
        for (int s = 0; s < NS; s += 17) begin
            qry_sect = 7'(s); #1;
            chk("R1 lock pair", int'(qry_lock), 0);
        end

        // R3 sweep of all codes, both anchors, all sectors; R5 whole erase per code
        for (int tb = 0; tb < 2; tb++) begin
            for (int bp = 0; bp < 8; bp++) begin
                do_req("R6 status write, pin low, freeze 0", K_STAT, 0, 8'((tb << 3) | bp), 1'b0);
                for (int s = 0; s < NS; s++) begin
                    do_req("R3 range", 3'(s % 3), s, 8'h00, 1'b1);
                end
                do_req("R5 whole erase vs code", K_BULK, 0, 8'h00, 1'b1);
            end
        end
        // idle after request: R7
        @(negedge clk);
        chk("R7 idle done", int'(rsp_done), 0);

        // R8 lock write under full range protection
        do_req("R8 status code 7", K_STAT, 0, 8'h07, 1'b1);
        do_req("R8 lock write under range", K_LOCK, 20, 8'h01, 1'b1);
        do_req("R8 program locked+range", K_PROG, 20, 8'h00, 1'b1);
        do_req("R8 lock clear", K_LOCK, 20, 8'h00, 1'b1);
        do_req("R8 status clear", K_STAT, 0, 8'h00, 1'b1);

        // R2 write-lock denies all three array operations
        do_req("R4 set write-lock", K_LOCK, 5, 8'h01, 1'b1);
        do_req("R2 program locked", K_PROG, 5, 8'h00, 1'b1);
        do_req("R2 subsector locked", K_SUB, 5, 8'h00, 1'b1);
        do_req("R2 sector locked", K_SEC, 5, 8'h00, 1'b1);
        do_req("R2 neighbour free", K_PROG, 6, 8'h00, 1'b1);
        do_req("R5 whole erase with lock", K_BULK, 0, 8'h00, 1'b1);
        do_req("R8 status write with lock", K_STAT, 0, 8'h00, 1'b1);
        do_req("R4 clear write-lock", K_LOCK, 5, 8'h00, 1'b1);
        do_req("R5 whole erase clean", K_BULK, 0, 8'h00, 1'b1);

        // R4 lock-down
        do_req("R4 set lock-down", K_LOCK, 9, 8'h02, 1'b1);
        do_req("R4 write under lock-down", K_LOCK, 9, 8'h01, 1'b1);
        do_req("R4 clear under lock-down", K_LOCK, 9, 8'h00, 1'b1);
        do_req("R2 program lock-down only", K_PROG, 9, 8'h00, 1'b1);
        do_req("R5 whole erase lock-down only", K_BULK, 0, 8'h00, 1'b1);
        do_req("R4 both bits sector 30", K_LOCK, 30, 8'h03, 1'b1);
        do_req("R2 program 30", K_SEC, 30, 8'h00, 1'b1);
        do_req("R4 unlock 30 refused", K_LOCK, 30, 8'h00, 1'b1);

        // R6 freeze by pin
        do_req("R6 set freeze code 2", K_STAT, 0, 8'h12, 1'b1);
        do_req("R6 frozen write", K_STAT, 0, 8'h00, 1'b0);
        do_req("R6 frozen write top", K_STAT, 0, 8'h0F, 1'b0);
        do_req("R6 pin high write", K_STAT, 0, 8'h00, 1'b1);

        // R4 reset clears lock-down
        do_reset();
        @(negedge clk);
        qry_sect = 7'd9; #1;
        chk("R4 reset clears lock-down", int'(qry_lock), 0);
        do_req("R4 write after reset", K_LOCK, 9, 8'h01, 1'b1);
        do_req("R4 unlock after reset", K_LOCK, 30, 8'h00, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule